// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small processor core built around a single accumulator. Words are 16 bits wide and memory is addressed in bytes. Each instruction runs as a fixed series of phases: fetch the opcode word, decode it, read the operand-address word that follows it, read the operand value from that address, then execute. Every memory read is split into one cycle that presents the address and one cycle that captures the returned data. The program counter moves forward one word (two bytes) for every instruction or operand word it fetches.

Two opcodes are recognised. The add instruction uses direct addressing: its second word is the absolute byte address of the value to add to the accumulator. The stop instruction has no operand word. Any other opcode raises an illegal-instruction output and stops the core in the same way as the stop instruction. The core talks to a synchronous memory with one cycle of read latency through a plain address, read strobe, write strobe, write data and read data port. An external reset restarts execution at a parameterised start address.

Top module: `acc_core`

## Requirements
- R1: While reset is held and after it is released, before the first fetch, the accumulator reads 0, status_o reads 0, illegal_o reads 0, pc_o equals the start address (0x0030 by default) and mem_rd is low.
- R2: The opcode word is read from the byte address in the program counter, and the program counter increases by exactly 2 after each word fetched from the instruction stream.
- R3: Opcode 0x0099 (add, direct) issues three reads in order: the opcode at PC, the operand-address word at PC+2, then the operand value at the byte address held in that word. Read data is captured the cycle after the read strobe.
- R4: Opcode 0x00FF (stop) sets status_o bit 1 (halt), leaves the other status bits unchanged, leaves pc_o just past the stop word, and no memory read occurs afterwards.
- R5: Executing add sets the accumulator to accumulator plus operand modulo 2^16. The accumulator changes at no other time.
- R6: Add sets status_o bit 0 (carry) to the carry out of bit 15 of the sum.
- R7: Add sets status_o bit 3 (zero) exactly when the 16-bit result is 0.
- R8: Add sets status_o bit 2 (negative) to bit 15 of the new accumulator.
- R9: Add sets status_o bit 4 (overflow) when both addends have the same sign and the sum has the other sign.
- R10: Any opcode other than 0x0099 and 0x00FF sets illegal_o and status_o bit 1, leaves the accumulator unchanged, and stops all further reads. Only reset clears illegal_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the core |
| mem_addr | output | 16 | Byte address driven to memory (the memory address register) |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe, held low because no instruction stores |
| mem_wdata | output | 16 | Write data, carries the accumulator |
| mem_rdata | input | 16 | Read data from memory |
| acc_o | output | 16 | Accumulator value |
| pc_o | output | 16 | Program counter value |
| status_o | output | 5 | Status bits: 0 carry, 1 halt, 2 negative, 3 zero, 4 overflow |
| illegal_o | output | 1 | Set when an unknown opcode has been decoded |

## Verification
The embedded assertions watch, on every cycle, that the program counter only ever moves by one word step, that the accumulator changes only in the execute phase, that the negative bit tracks the accumulator's top bit after each add, that an illegal opcode always comes with the halt bit, and that a halted core never strobes memory. Only the directed programs can show the order and addresses of the three reads of an add, the arithmetic results and the carry, zero and overflow values for chosen operand pairs, and that a stop keeps the earlier flags.

// File: rtl/acc_core_pkg.sv
package acc_core_pkg;

  typedef enum logic [3:0] {
    PH_IF_ADDR,
    PH_IF_READ,
    PH_IF_CAPT,
    PH_DECODE,
    PH_OA_ADDR,
    PH_OA_READ,
    PH_OA_CAPT,
    PH_OV_ADDR,
    PH_OV_READ,
    PH_OV_CAPT,
    PH_EXEC,
    PH_STOP
  } phase_t;

  // bit 0 carry, bit 1 halt, bit 2 negative, bit 3 zero, bit 4 overflow
  typedef struct packed {
    logic ovf;
    logic zero;
    logic neg;
    logic halt;
    logic carry;
  } flags_t;

  typedef struct packed {
    logic mar_from_pc;
    logic mar_from_opa;
    logic rd_req;
    logic pc_adv;
    logic cap_opcode;
    logic cap_opaddr;
    logic cap_value;
    logic exec_add;
    logic set_halt;
    logic set_bad_op;
  } ctl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] sum_o,
  output logic          carry_o,
  output logic          ovf_o,
  output logic          zero_o,
  output logic          neg_o
);

  logic [DW:0] wide_sum;

  always_comb begin
    wide_sum = {1'b0, a_i} + {1'b0, b_i};
    sum_o    = wide_sum[DW-1:0];
    carry_o  = wide_sum[DW];
    neg_o    = wide_sum[DW-1];
    zero_o   = (wide_sum[DW-1:0] == '0);
    ovf_o    = (a_i[DW-1] == b_i[DW-1]) && (wide_sum[DW-1] != a_i[DW-1]);
  end

endmodule

// File: rtl/acc_seq.sv
module acc_seq
  import acc_core_pkg::*;
#(
  parameter int            DW       = 16,
  parameter logic [DW-1:0] OPC_ADD  = 16'h0099,
  parameter logic [DW-1:0] OPC_STOP = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] opcode_i,
  output ctl_t          ctl_o,
  output phase_t        phase_o
);

  phase_t ph_q, ph_d;
  ctl_t   ctl;

  always_comb begin
    ph_d = ph_q;
    ctl  = '0;
    case (ph_q)
      PH_IF_ADDR: begin ctl.mar_from_pc = 1'b1;                     ph_d = PH_IF_READ; end
      PH_IF_READ: begin ctl.rd_req = 1'b1; ctl.pc_adv = 1'b1;       ph_d = PH_IF_CAPT; end
      PH_IF_CAPT: begin ctl.cap_opcode = 1'b1;                      ph_d = PH_DECODE;  end
      PH_DECODE: begin
        if (opcode_i == OPC_ADD) begin
          ph_d = PH_OA_ADDR;
        end else if (opcode_i == OPC_STOP) begin
          ctl.set_halt = 1'b1;
          ph_d         = PH_STOP;
        end else begin
          ctl.set_halt   = 1'b1;
          ctl.set_bad_op = 1'b1;
          ph_d           = PH_STOP;
        end
      end
      PH_OA_ADDR: begin ctl.mar_from_pc = 1'b1;                     ph_d = PH_OA_READ; end
      PH_OA_READ: begin ctl.rd_req = 1'b1; ctl.pc_adv = 1'b1;       ph_d = PH_OA_CAPT; end
      PH_OA_CAPT: begin ctl.cap_opaddr = 1'b1;                      ph_d = PH_OV_ADDR; end
      PH_OV_ADDR: begin ctl.mar_from_opa = 1'b1;                    ph_d = PH_OV_READ; end
      PH_OV_READ: begin ctl.rd_req = 1'b1;                          ph_d = PH_OV_CAPT; end
      PH_OV_CAPT: begin ctl.cap_value = 1'b1;                       ph_d = PH_EXEC;    end
      PH_EXEC:    begin ctl.exec_add = 1'b1;                        ph_d = PH_IF_ADDR; end
      PH_STOP:    begin                                             ph_d = PH_STOP;    end
      default:    begin                                             ph_d = PH_STOP;    end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_IF_ADDR;
    else        ph_q <= ph_d;
  end

  assign ctl_o   = ctl;
  assign phase_o = ph_q;

  AST_STOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_STOP) |=> (ph_q == PH_STOP)); // R4

  AST_ONE_READ_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.rd_req |=> !ctl.rd_req); // R3

endmodule

// File: rtl/acc_dp.sv
module acc_dp
  import acc_core_pkg::*;
#(
  parameter int            DW         = 16,
  parameter int            AW         = 16,
  parameter logic [AW-1:0] START_ADDR = 16'h0030
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl_i,
  input  logic [DW-1:0] rdata_i,
  input  logic [DW-1:0] alu_sum_i,
  input  logic          alu_carry_i,
  input  logic          alu_ovf_i,
  input  logic          alu_zero_i,
  input  logic          alu_neg_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] mar_o,
  output logic [DW-1:0] mdr_o,
  output logic [DW-1:0] opcode_o,
  output logic [DW-1:0] acc_o,
  output flags_t        flags_o,
  output logic          bad_op_o
);

  localparam logic [AW-1:0] PC_STEP = AW'(DW / 8);

  logic [AW-1:0] pc_q, pc_d;
  logic [AW-1:0] mar_q, mar_d;
  logic [DW-1:0] mdr_q, mdr_d;
  logic [DW-1:0] opc_q, opc_d;
  logic [AW-1:0] opa_q, opa_d;
  logic [DW-1:0] acc_q, acc_d;
  flags_t        flg_q, flg_d;
  logic          bad_q, bad_d;

  always_comb begin
    pc_d  = pc_q;
    mar_d = mar_q;
    mdr_d = mdr_q;
    opc_d = opc_q;
    opa_d = opa_q;
    acc_d = acc_q;
    flg_d = flg_q;
    bad_d = bad_q;

    if (ctl_i.pc_adv)       pc_d  = pc_q + PC_STEP;
    if (ctl_i.mar_from_pc)  mar_d = pc_q;
    if (ctl_i.mar_from_opa) mar_d = opa_q;
    if (ctl_i.cap_opcode || ctl_i.cap_opaddr || ctl_i.cap_value) mdr_d = rdata_i;
    if (ctl_i.cap_opcode)   opc_d = rdata_i;
    if (ctl_i.cap_opaddr)   opa_d = rdata_i[AW-1:0];
    if (ctl_i.exec_add) begin
      acc_d      = alu_sum_i;
      flg_d.carry = alu_carry_i;
      flg_d.neg   = alu_neg_i;
      flg_d.zero  = alu_zero_i;
      flg_d.ovf   = alu_ovf_i;
    end
    if (ctl_i.set_halt)   flg_d.halt = 1'b1;
    if (ctl_i.set_bad_op) bad_d      = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= START_ADDR;
      mar_q <= START_ADDR;
      mdr_q <= '0;
      opc_q <= '0;
      opa_q <= '0;
      acc_q <= '0;
      flg_q <= '0;
      bad_q <= 1'b0;
    end else begin
      pc_q  <= pc_d;
      mar_q <= mar_d;
      mdr_q <= mdr_d;
      opc_q <= opc_d;
      opa_q <= opa_d;
      acc_q <= acc_d;
      flg_q <= flg_d;
      bad_q <= bad_d;
    end
  end

  assign pc_o     = pc_q;
  assign mar_o    = mar_q;
  assign mdr_o    = mdr_q;
  assign opcode_o = opc_q;
  assign acc_o    = acc_q;
  assign flags_o  = flg_q;
  assign bad_op_o = bad_q;

  AST_PC_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_q != $past(pc_q)) |-> (pc_q == $past(pc_q) + PC_STEP)); // R2

  AST_ACC_ONLY_IN_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ctl_i.exec_add) |-> (acc_q == $past(acc_q))); // R5

  AST_NEG_TRACKS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_i.exec_add) |-> (flg_q.neg == acc_q[DW-1])); // R8

  AST_BAD_OP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    bad_q |-> flg_q.halt); // R10

endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_core_pkg::*;
#(
  parameter int            DW         = 16,
  parameter int            AW         = 16,
  parameter logic [AW-1:0] START_ADDR = 16'h0030,
  parameter logic [DW-1:0] OPC_ADD    = 16'h0099,
  parameter logic [DW-1:0] OPC_STOP   = 16'h00FF
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] acc_o,
  output logic [AW-1:0] pc_o,
  output logic [4:0]    status_o,
  output logic          illegal_o
);

  logic [1:0]    rst_sync_q;
  logic          core_rst_n;
  ctl_t          ctl;
  phase_t        phase;
  logic [DW-1:0] opcode;
  logic [DW-1:0] mdr;
  logic [DW-1:0] acc;
  logic [AW-1:0] mar;
  flags_t        flags;
  logic [DW-1:0] alu_sum;
  logic          alu_carry, alu_ovf, alu_zero, alu_neg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  acc_seq #(
    .DW       (DW),
    .OPC_ADD  (OPC_ADD),
    .OPC_STOP (OPC_STOP)
  ) u_seq (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .opcode_i (opcode),
    .ctl_o    (ctl),
    .phase_o  (phase)
  );

  acc_alu #(.DW(DW)) u_alu (
    .a_i     (acc),
    .b_i     (mdr),
    .sum_o   (alu_sum),
    .carry_o (alu_carry),
    .ovf_o   (alu_ovf),
    .zero_o  (alu_zero),
    .neg_o   (alu_neg)
  );

  acc_dp #(
    .DW         (DW),
    .AW         (AW),
    .START_ADDR (START_ADDR)
  ) u_dp (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .ctl_i       (ctl),
    .rdata_i     (mem_rdata),
    .alu_sum_i   (alu_sum),
    .alu_carry_i (alu_carry),
    .alu_ovf_i   (alu_ovf),
    .alu_zero_i  (alu_zero),
    .alu_neg_i   (alu_neg),
    .pc_o        (pc_o),
    .mar_o       (mar),
    .mdr_o       (mdr),
    .opcode_o    (opcode),
    .acc_o       (acc),
    .flags_o     (flags),
    .bad_op_o    (illegal_o)
  );

  assign mem_addr  = mar;
  assign mem_rd    = ctl.rd_req;
  assign mem_wr    = 1'b0;
  assign mem_wdata = acc;
  assign acc_o     = acc;
  assign status_o  = flags;

  AST_HALTED_NO_READ: assert property (@(posedge clk) disable iff (!core_rst_n)
    status_o[1] |-> !mem_rd); // R4

  AST_STOP_PHASE_HALTED: assert property (@(posedge clk) disable iff (!core_rst_n)
    $past(phase == PH_DECODE) && (phase == PH_STOP) |-> status_o[1]); // R4

endmodule

// File: tb/acc_core_tb.sv
module acc_core_tb;

  logic        clk;
  logic        rst_n;
  logic [15:0] mem_addr;
  logic        mem_rd;
  logic        mem_wr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata;
  logic [15:0] acc_o;
  logic [15:0] pc_o;
  logic [4:0]  status_o;
  logic        illegal_o;

  logic [15:0] mem [0:255];
  logic [15:0] rd_log [0:31];
  int          rd_cnt;
  int          n_checks;
  int          n_fails;

  acc_core u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .acc_o     (acc_o),
    .pc_o      (pc_o),
    .status_o  (status_o),
    .illegal_o (illegal_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // behavioural memory, one cycle read latency, word index = byte address / 2
  always @(posedge clk) begin
    if (!rst_n) begin
      rd_cnt = 0;
    end else if (mem_rd) begin
      mem_rdata <= mem[mem_addr[8:1]];
      if (rd_cnt < 32) rd_log[rd_cnt] = mem_addr;
      rd_cnt = rd_cnt + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h00FF;
  endtask

  task automatic put(input logic [15:0] byte_addr, input logic [15:0] val);
    mem[byte_addr[8:1]] = val;
  endtask

  task automatic run_prog();
    bit done;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    done = 1'b0;
    for (int i = 0; i < 400 && !done; i++) begin
      @(negedge clk);
      if (status_o[1]) done = 1'b1;
    end
    chk("run reached halt", {31'd0, done}, 32'd1);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 acc in reset", acc_o, 32'h0);
    chk("R1 status in reset", status_o, 32'h0);
    chk("R1 illegal in reset", illegal_o, 32'h0);
    chk("R1 pc in reset", pc_o, 32'h0030);
    chk("R1 no read in reset", mem_rd, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after release", pc_o, 32'h0030);
    chk("R1 acc after release", acc_o, 32'h0);
  endtask

  task automatic t_add_program();
    clear_mem();
    put(16'h0030, 16'h0099); put(16'h0032, 16'h0040);
    put(16'h0034, 16'h0099); put(16'h0036, 16'h0042);
    put(16'h0038, 16'h00FF);
    put(16'h0040, 16'h0005); put(16'h0042, 16'h0001);
    run_prog();
    chk("R5 acc 5+1", acc_o, 32'h0006);
    chk("R4 status after stop", status_o, 32'h02);
    chk("R2 pc past stop word", pc_o, 32'h003A);
    chk("R3 read count", rd_cnt, 32'd7);
    chk("R2 read0 opcode at pc", rd_log[0], 32'h0030);
    chk("R3 read1 operand address word", rd_log[1], 32'h0032);
    chk("R3 read2 operand value", rd_log[2], 32'h0040);
    chk("R2 read3 next opcode", rd_log[3], 32'h0034);
    chk("R3 read5 second value", rd_log[5], 32'h0042);
    chk("R4 read6 stop opcode", rd_log[6], 32'h0038);
    repeat (20) @(negedge clk);
    chk("R4 no reads after stop", rd_cnt, 32'd7);
    chk("R4 pc frozen after stop", pc_o, 32'h003A);
    chk("R10 illegal stays low", illegal_o, 32'h0);
  endtask

  task automatic t_carry_zero();
    clear_mem();
    put(16'h0030, 16'h0099); put(16'h0032, 16'h0050);
    put(16'h0034, 16'h0099); put(16'h0036, 16'h0052);
    put(16'h0038, 16'h00FF);
    put(16'h0050, 16'hFFFF); put(16'h0052, 16'h0001);
    run_prog();
    chk("R5 acc wraps to 0", acc_o, 32'h0000);
    chk("R6 carry set", status_o[0], 32'h1);
    chk("R7 zero set", status_o[3], 32'h1);
    chk("R8 negative clear", status_o[2], 32'h0);
    chk("R9 overflow clear", status_o[4], 32'h0);
    chk("R4 stop keeps flags", status_o, 32'h0B);
  endtask

  task automatic t_pos_overflow();
    clear_mem();
    put(16'h0030, 16'h0099); put(16'h0032, 16'h0060);
    put(16'h0034, 16'h0099); put(16'h0036, 16'h0062);
    put(16'h0038, 16'h00FF);
    put(16'h0060, 16'h7FFF); put(16'h0062, 16'h0001);
    run_prog();
    chk("R5 acc 7fff+1", acc_o, 32'h8000);
    chk("R9 overflow on positive pair", status_o[4], 32'h1);
    chk("R8 negative from msb", status_o[2], 32'h1);
    chk("R6 no carry", status_o[0], 32'h0);
    chk("R7 zero clear", status_o[3], 32'h0);
  endtask

  task automatic t_neg_overflow();
    clear_mem();
    put(16'h0030, 16'h0099); put(16'h0032, 16'h0070);
    put(16'h0034, 16'h0099); put(16'h0036, 16'h0070);
    put(16'h0038, 16'h00FF);
    put(16'h0070, 16'h8000);
    run_prog();
    chk("R5 acc 8000+8000", acc_o, 32'h0000);
    chk("R9 R6 R7 flags on negative pair", status_o, 32'h1B);
  endtask

  task automatic t_single_no_flags();
    clear_mem();
    put(16'h0030, 16'h0099); put(16'h0032, 16'h0080);
    put(16'h0034, 16'h00FF);
    put(16'h0080, 16'h1234);
    run_prog();
    chk("R5 acc 0+1234", acc_o, 32'h1234);
    chk("R6 R7 R8 R9 flags clear", status_o, 32'h02);
  endtask

  task automatic t_illegal();
    clear_mem();
    put(16'h0030, 16'h1234);
    run_prog();
    chk("R10 illegal set", illegal_o, 32'h1);
    chk("R10 halt bit with illegal", status_o, 32'h02);
    chk("R10 acc unchanged", acc_o, 32'h0);
    chk("R10 pc past bad word", pc_o, 32'h0032);
    repeat (20) @(negedge clk);
    chk("R10 only one read", rd_cnt, 32'd1);
  endtask

  initial begin
    rst_n     = 1'b0;
    mem_rdata = '0;
    rd_cnt    = 0;
    n_checks  = 0;
    n_fails   = 0;
    clear_mem();
    t_reset_state();
    t_add_program();
    t_carry_zero();
    t_pos_overflow();
    t_neg_overflow();
    t_single_no_flags();
    t_illegal();
    t_reset_state();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #1000000;
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule